// File: doc/BRIEF.md
# Snapshot Statistics Counter Bank

This block keeps six free-running event counters for a packet datapath: start, end and error events on the transmit side, and the same three on the receive side. Each event input is a one-cycle pulse. Software reads every counter as two 32-bit words through a simple register port. Each read is registered, so its data comes back one cycle after the request.

One counter value is wider than a bus word, so software reading the low half and then the high half could see a carry land between the two reads. To prevent this, software sets a hold bit in the control register. That single write copies all six live counters into shadow registers in the same edge. While the hold bit stays set, reads return the frozen copies and the live counters keep counting underneath. A second control bit zeroes the shadow copies. A third control bit zeroes the live counters.

Top module: `stat_snapshot_bank`

## Requirements
- R1: After reset, every counter word and the control register read as zero.
- R2: Event input bit k drives counter k only: bit 0 transmit start, bit 1 transmit end, bit 2 transmit error, bit 3 receive start, bit 4 receive end, bit 5 receive error. Each cycle the bit is high adds one to that counter.
- R3: Counter k has its low word at byte address 0x20+8k and its high word at 0x24+8k. A read request returns its data, with the valid flag high, exactly one cycle later. The valid flag is low in any cycle that follows no request.
- R4: The control register sits at address 0x00. Bit 6 is snapshot hold, bit 7 is snapshot clear and bit 8 is live clear. The register reads back these three bits, and every other bit reads as zero.
- R5: A write that changes bit 6 from 0 to 1 copies all six live counters into the shadow registers. The copied values are those before any events of that same cycle. While bit 6 stays set, counter reads return the copied values and the live counters keep counting.
- R6: While bit 6 is clear, counter reads return the live values.
- R7: Starting one cycle after bit 7 is written as 1, and for as long as it stays set, the shadow registers are held at zero. A capture attempted during that time is lost.
- R8: Starting one cycle after bit 8 is written as 1, and for as long as it stays set, the live counters are held at zero. An event that arrives during that time leaves its counter at zero.
- R9: A counter that holds its maximum value (all ones over the parameter CNT_W, 64 by default) goes to zero on the next event.
- R10: Writes to counter addresses or unmapped addresses change nothing. Reads of unmapped or misaligned addresses return zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cnt_evt | input | 6 | Event pulses, one bit per counter |
| bus_wr | input | 1 | Write request |
| bus_rd | input | 1 | Read request |
| bus_addr | input | 8 | Byte address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, one cycle after the request |
| bus_rvalid | output | 1 | Read data valid |

## Verification
Two kinds of cycle overlap are tested. In the first, a capture coincides with event pulses: the write that sets the hold bit also drives all six events high. The frozen words are then expected to omit that cycle's events, while the live words include them. In the second, an event arrives while a clear is active, or a capture is attempted while the shadow clear is active. In both cases the affected registers must read zero. A second instance with 4-bit counters runs the same stimulus, so a wrap to zero can be seen and compared against the reference count modulo 16.

// File: rtl/stat_pkg.sv
package stat_pkg;

    localparam int NUM_CNT  = 6;
    localparam int ADDR_W   = 8;
    localparam int WORD_W   = 32;
    localparam int VIEW_W   = 2 * WORD_W;
    localparam int IDX_W    = $clog2(NUM_CNT);
    localparam int CNT_SPAN = NUM_CNT * 8;

    localparam logic [ADDR_W-1:0] CTRL_ADDR = 8'h00;
    localparam logic [ADDR_W-1:0] CNT_BASE  = 8'h20;

    localparam int BIT_SNAP_HOLD = 6;
    localparam int BIT_SNAP_CLR  = 7;
    localparam int BIT_LIVE_CLR  = 8;

    typedef struct packed {
        logic live_clr;
        logic snap_clr;
        logic snap_hold;
    } ctrl_t;

    typedef enum logic [1:0] {
        SRC_NONE,
        SRC_CTRL,
        SRC_CNT
    } rd_src_e;

    typedef struct packed {
        logic             ctrl_hit;
        logic             cnt_hit;
        logic [IDX_W-1:0] idx;
        logic             hi;
    } dec_t;

    function automatic dec_t decode(input logic [ADDR_W-1:0] a);
        dec_t                d;
        logic [ADDR_W-1:0]   off;
        off        = a - CNT_BASE;
        d.ctrl_hit = (a == CTRL_ADDR);
        d.cnt_hit  = (a >= CNT_BASE) && (int'(off) < CNT_SPAN) && (a[1:0] == 2'b00);
        d.idx      = off[IDX_W+2:3];
        d.hi       = off[2];
        return d;
    endfunction

    function automatic logic [WORD_W-1:0] ctrl_word(input ctrl_t c);
        logic [WORD_W-1:0] w;
        w                = '0;
        w[BIT_SNAP_HOLD] = c.snap_hold;
        w[BIT_SNAP_CLR]  = c.snap_clr;
        w[BIT_LIVE_CLR]  = c.live_clr;
        return w;
    endfunction

endpackage

// File: rtl/stat_live_counter.sv
module stat_live_counter #(
    parameter int CNT_W = 64
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             clr,
    input  logic             inc,
    output logic [CNT_W-1:0] q
);

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            q <= '0;
        end else if (inc) begin
            q <= q + CNT_W'(1);
        end
    end

    assert_clear_wins_R8: assert property (@(posedge clk) disable iff (rst)
        clr |=> (q == '0));

    assert_wrap_R9: assert property (@(posedge clk) disable iff (rst)
        (!clr && inc && (q == '1)) |=> (q == '0));

    assert_idle_stable_R2: assert property (@(posedge clk) disable iff (rst)
        (!clr && !inc) |=> $stable(q));

endmodule

// File: rtl/stat_shadow_reg.sv
module stat_shadow_reg #(
    parameter int CNT_W = 64
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             clr,
    input  logic             cap,
    input  logic [CNT_W-1:0] live,
    output logic [CNT_W-1:0] q
);

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            q <= '0;
        end else if (cap) begin
            q <= live;
        end
    end

    assert_capture_copies_R5: assert property (@(posedge clk) disable iff (rst)
        (cap && !clr) |=> (q == $past(live)));

    assert_frozen_R5: assert property (@(posedge clk) disable iff (rst)
        (!cap && !clr) |=> $stable(q));

    assert_shadow_clear_R7: assert property (@(posedge clk) disable iff (rst)
        clr |=> (q == '0));

endmodule

// File: rtl/stat_ctrl_reg.sv
module stat_ctrl_reg
    import stat_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  wr_sel,
    input  ctrl_t wr_val,
    output ctrl_t ctrl_q,
    output logic  snap_cap
);

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl_q <= '0;
        end else if (wr_sel) begin
            ctrl_q <= wr_val;
        end
    end

    // capture only on a 0 -> 1 change of the hold bit
    assign snap_cap = wr_sel && wr_val.snap_hold && !ctrl_q.snap_hold;

    assert_cap_sets_hold_R5: assert property (@(posedge clk) disable iff (rst)
        snap_cap |=> ctrl_q.snap_hold);

    assert_ctrl_kept_R4: assert property (@(posedge clk) disable iff (rst)
        !wr_sel |=> $stable(ctrl_q));

endmodule

// File: rtl/stat_read_port.sv
module stat_read_port
    import stat_pkg::*;
#(
    parameter int CNT_W = 64
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              rd_en,
    input  logic [ADDR_W-1:0] addr,
    input  ctrl_t             ctrl,
    input  logic [CNT_W-1:0]  live [NUM_CNT],
    input  logic [CNT_W-1:0]  shd  [NUM_CNT],
    output logic [WORD_W-1:0] rdata,
    output logic              rvalid
);

    dec_t              dec;
    rd_src_e           src;
    logic [VIEW_W-1:0] view;
    logic [WORD_W-1:0] word;

    always_comb begin
        dec = decode(addr);
        if (dec.ctrl_hit) begin
            src = SRC_CTRL;
        end else if (dec.cnt_hit) begin
            src = SRC_CNT;
        end else begin
            src = SRC_NONE;
        end

        view = '0;
        if (dec.cnt_hit && (int'(dec.idx) < NUM_CNT)) begin
            view = ctrl.snap_hold ? VIEW_W'(shd[dec.idx]) : VIEW_W'(live[dec.idx]);
        end

        case (src)
            SRC_CTRL: word = ctrl_word(ctrl);
            SRC_CNT:  word = dec.hi ? view[VIEW_W-1:WORD_W] : view[WORD_W-1:0];
            default:  word = '0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rvalid <= 1'b0;
            rdata  <= '0;
        end else begin
            rvalid <= rd_en;
            rdata  <= rd_en ? word : '0;
        end
    end

    assert_read_latency_R3: assert property (@(posedge clk) disable iff (rst)
        rd_en |=> rvalid);

    assert_no_spurious_valid_R3: assert property (@(posedge clk) disable iff (rst)
        !rd_en |=> !rvalid);

    assert_unmapped_zero_R10: assert property (@(posedge clk) disable iff (rst)
        (rd_en && (src == SRC_NONE)) |=> (rdata == '0));

endmodule

// File: rtl/stat_snapshot_bank.sv
module stat_snapshot_bank
    import stat_pkg::*;
#(
    parameter int CNT_W = 64
) (
    input  logic        clk,
    input  logic        rst,
    input  logic [5:0]  cnt_evt,
    input  logic        bus_wr,
    input  logic        bus_rd,
    input  logic [7:0]  bus_addr,
    input  logic [31:0] bus_wdata,
    output logic [31:0] bus_rdata,
    output logic        bus_rvalid
);

    ctrl_t            ctrl_q;
    ctrl_t            wr_val;
    logic             wr_sel;
    logic             snap_cap;
    logic [CNT_W-1:0] live_q [NUM_CNT];
    logic [CNT_W-1:0] shd_q  [NUM_CNT];
    logic             wdata_unused;

    assign wr_sel           = bus_wr && decode(bus_addr).ctrl_hit;
    assign wr_val.snap_hold = bus_wdata[BIT_SNAP_HOLD];
    assign wr_val.snap_clr  = bus_wdata[BIT_SNAP_CLR];
    assign wr_val.live_clr  = bus_wdata[BIT_LIVE_CLR];
    assign wdata_unused     = ^{bus_wdata[WORD_W-1:BIT_LIVE_CLR+1], bus_wdata[BIT_SNAP_HOLD-1:0]};

    stat_ctrl_reg u_ctrl (
        .clk      (clk),
        .rst      (rst),
        .wr_sel   (wr_sel),
        .wr_val   (wr_val),
        .ctrl_q   (ctrl_q),
        .snap_cap (snap_cap)
    );

    for (genvar g = 0; g < NUM_CNT; g++) begin : g_cnt
        stat_live_counter #(.CNT_W(CNT_W)) u_live (
            .clk (clk),
            .rst (rst),
            .clr (ctrl_q.live_clr),
            .inc (cnt_evt[g]),
            .q   (live_q[g])
        );

        stat_shadow_reg #(.CNT_W(CNT_W)) u_shd (
            .clk  (clk),
            .rst  (rst),
            .clr  (ctrl_q.snap_clr),
            .cap  (snap_cap),
            .live (live_q[g]),
            .q    (shd_q[g])
        );
    end

    stat_read_port #(.CNT_W(CNT_W)) u_rd (
        .clk    (clk),
        .rst    (rst),
        .rd_en  (bus_rd),
        .addr   (bus_addr),
        .ctrl   (ctrl_q),
        .live   (live_q),
        .shd    (shd_q),
        .rdata  (bus_rdata),
        .rvalid (bus_rvalid)
    );

    assert_rom_writes_ignored_R10: assert property (@(posedge clk) disable iff (rst)
        (bus_wr && !wr_sel) |=> $stable(ctrl_q));

endmodule

// File: tb/stat_snapshot_bank_tb_top.sv
module stat_snapshot_bank_tb_top;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [5:0]  evt = '0;
    logic        wr_en = 1'b0;
    logic        rd_en = 1'b0;
    logic [7:0]  addr = '0;
    logic [31:0] wdata = '0;
    logic [31:0] rdata, rdata_w;
    logic        rvalid, rvalid_w;

    always #10 clk = ~clk;

    stat_snapshot_bank dut_i (
        .clk(clk), .rst(rst), .cnt_evt(evt), .bus_wr(wr_en), .bus_rd(rd_en),
        .bus_addr(addr), .bus_wdata(wdata), .bus_rdata(rdata), .bus_rvalid(rvalid)
    );

    stat_snapshot_bank #(.CNT_W(4)) dut_wrap (
        .clk(clk), .rst(rst), .cnt_evt(evt), .bus_wr(wr_en), .bus_rd(rd_en),
        .bus_addr(addr), .bus_wdata(wdata), .bus_rdata(rdata_w), .bus_rvalid(rvalid_w)
    );

    typedef struct {
        logic [31:0] exp;
        logic [31:0] expw;
        string       tag;
    } item_t;

    item_t       sbq[$];
    int          checks = 0;
    int          fails  = 0;
    bit          done   = 0;

    logic [63:0] live_m [6];
    logic [63:0] shd_m  [6];
    bit          snap_m, sclr_m, lclr_m;

    function automatic logic [31:0] expect_word(input logic [7:0] a, input bit narrow);
        logic [63:0] v;
        int          k;
        if (a == 8'h00) return {23'b0, lclr_m, sclr_m, snap_m, 6'b0};
        if (a >= 8'h20 && a <= 8'h4C && a[1:0] == 2'b00) begin
            k = int'(a - 8'h20) >> 3;
            v = snap_m ? shd_m[k] : live_m[k];
            if (narrow) v = v & 64'hF;
            return a[2] ? v[63:32] : v[31:0];
        end
        return 32'h0;
    endfunction

    task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // one bus cycle; caller is at a falling edge
    task automatic step(input bit we, input logic [7:0] a, input logic [31:0] d,
                        input logic [5:0] e, input bit re, input string tag);
        bit cap;
        wr_en = we; addr = a; wdata = d; evt = e; rd_en = re;
        if (re) sbq.push_back('{exp: expect_word(a, 0), expw: expect_word(a, 1), tag: tag});
        @(posedge clk);
        cap = we && a == 8'h00 && d[6] && !snap_m;
        for (int k = 0; k < 6; k++) begin
            if (sclr_m) shd_m[k] = '0;
            else if (cap) shd_m[k] = live_m[k];
        end
        for (int k = 0; k < 6; k++) begin
            if (lclr_m) live_m[k] = '0;
            else if (e[k]) live_m[k] = live_m[k] + 64'd1;
        end
        if (we && a == 8'h00) begin
            snap_m = d[6]; sclr_m = d[7]; lclr_m = d[8];
        end
        @(negedge clk);
        wr_en = 0; rd_en = 0; evt = '0;
    endtask

    task automatic read_all(input string tag);
        for (int a = 8'h20; a <= 8'h4C; a += 4) step(0, 8'(a), 0, 0, 1, tag);
    endtask

    task automatic pulse(input logic [5:0] e, input int n);
        for (int i = 0; i < n; i++) step(0, 8'h00, 0, e, 0, "");
    endtask

    // scoreboard monitor
    always @(negedge clk) begin
        if (!rst && rvalid) begin
            if (sbq.size() == 0) begin
                check(0, "R3 unexpected valid", rdata, 32'h0);
            end else begin
                item_t it;
                it = sbq.pop_front();
                check(rdata == it.exp, it.tag, rdata, it.exp);
                check(rvalid_w && rdata_w == it.expw, {it.tag, " narrow"}, rdata_w, it.expw);
            end
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++; fails++;
            $display("FAIL watchdog expired actual=running expected=done");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    initial begin
        for (int k = 0; k < 6; k++) begin live_m[k] = '0; shd_m[k] = '0; end
        snap_m = 0; sclr_m = 0; lclr_m = 0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        check(rvalid == 1'b0, "R3 valid low after reset", 32'(rvalid), 32'h0);

        // R1 reset state
        read_all("R1 reset counter");
        step(0, 8'h00, 0, 0, 1, "R1 reset ctrl");

        // R2 event routing, R3 map
        pulse(6'b000001, 3);
        pulse(6'b101010, 2);
        pulse(6'b111111, 1);
        pulse(6'b010100, 5);
        read_all("R2 R3 live counts");

        // R5 capture in a cycle with events
        step(1, 8'h00, 32'h40, 6'b111111, 0, "");
        pulse(6'b011001, 4);
        read_all("R5 frozen copy");
        step(0, 8'h00, 0, 0, 1, "R4 ctrl hold readback");

        // R6 live view after release
        step(1, 8'h00, 32'h00, 0, 0, "");
        read_all("R6 live view");

        // R7 shadow clear and lost capture
        step(1, 8'h00, 32'h40, 0, 0, "");
        pulse(6'b100000, 2);
        step(1, 8'h00, 32'hC0, 0, 0, "");
        step(0, 8'h00, 0, 0, 0, "");
        read_all("R7 shadow cleared");
        step(1, 8'h00, 32'h80, 0, 0, "");
        step(1, 8'h00, 32'hC0, 6'b000011, 0, "");
        read_all("R7 capture lost");
        step(1, 8'h00, 32'h40, 0, 0, "");
        read_all("R7 capture while clear drops");
        step(1, 8'h00, 32'h00, 0, 0, "");

        // R8 live clear with events pending
        step(1, 8'h00, 32'h100, 0, 0, "");
        pulse(6'b111111, 2);
        read_all("R8 live held zero");
        step(1, 8'h00, 32'h00, 6'b111111, 0, "");
        pulse(6'b110011, 3);
        read_all("R8 counting resumes");

        // R10 ignored writes and unmapped reads
        step(1, 8'h20, 32'hFFFFFFFF, 0, 0, "");
        step(1, 8'h4C, 32'hFFFFFFFF, 0, 0, "");
        step(1, 8'h50, 32'hFFFFFFFF, 0, 0, "");
        read_all("R10 counters untouched");
        step(0, 8'h00, 0, 0, 1, "R10 ctrl untouched");
        step(0, 8'h50, 0, 0, 1, "R10 unmapped read");
        step(0, 8'h22, 0, 0, 1, "R10 misaligned read");
        step(0, 8'h04, 0, 0, 1, "R10 gap read");

        // R4 reserved bits
        step(1, 8'h00, 32'hFFFFFFFF, 0, 0, "");
        step(0, 8'h00, 0, 0, 1, "R4 reserved bits zero");
        step(1, 8'h00, 32'h00, 0, 0, "");
        step(1, 8'h00, 32'h00, 0, 0, "");

        // R9 wrap of the narrow instance
        pulse(6'b000001, 17);
        step(0, 8'h20, 0, 0, 1, "R9 wrap low word");
        step(0, 8'h24, 0, 0, 1, "R9 wrap high word");

        repeat (3) @(negedge clk);
        check(sbq.size() == 0, "R3 all reads answered", 32'(sbq.size()), 32'h0);
        done = 1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

endmodule